// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block plays the memory side of a three-wire serial EEPROM link. It is synthesizable, so a controller under test can be paired with it in a simulation or on an emulation board. A master raises chip select and toggles the serial clock. On each rising serial clock edge it presents one bit on the data input line: first a three-bit command, then the word address. When the command is a read, the responder begins driving its data output right after the last address bit. It sends one zero bit, then the sixteen bits of the addressed word.

The leading zero appears on the wire exactly when the address is complete. This lets a master find out how many address bits the part takes. The master probes the data line after each address bit, and the first zero it sees marks the end of the address. The memory holds 64 or 256 sixteen-bit words, set by a parameter, so the address is 6 or 8 bits long. Before the serial traffic starts, the words are loaded through a parallel write port.

All inputs are taken to be synchronous to the block clock. The serial clock is oversampled, and its edges are found by comparing its current level with the level seen one block clock earlier.

Top module: `ee_responder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `sdo_oe` and `sdo` are both 0.
- R2: A block clock edge with `load_en` high stores `load_data` at word `load_addr`. A later read of that address returns the stored value.
- R3: With `sel` high, bits are taken from `sdi` on rising `sclk` edges. The first three bits form the command, most significant bit first. The value 3'b110 selects a read. The address follows, most significant bit first, and is 6 bits wide when `WORDS`=64 and 8 bits wide when `WORDS`=256.
- R4: During a read, `sdo_oe` stays 0 until the rising `sclk` edge that delivers the last address bit.
- R5: One block clock after that rising edge, `sdo_oe` is 1 and `sdo` is 0. This is the dummy zero bit.
- R6: Each of the next 16 falling `sclk` edges presents the next bit of the addressed word on `sdo`, starting from bit 15. `sdo` changes only after falling edges, so it holds steady while `sclk` is high.
- R7: The falling `sclk` edge after bit 0 has been presented sets `sdo_oe` back to 0, with `sdo` at 0.
- R8: Whenever `sel` is low, the responder returns to waiting for a command, with its bit count cleared. `sdo_oe` is 0 one block clock later, and the next frame decodes from its first bit.
- R9: A command other than 3'b110 leaves `sdo_oe` at 0 for the rest of the frame, whatever follows on `sdi`, until `sel` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Parallel preload write strobe |
| load_addr | input | AW ($clog2(WORDS)) | Word address for the preload |
| load_data | input | DW (16) | Word value for the preload |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial command and address bits from the master |
| sdo | output | 1 | Serial data to the master; 0 when not driven |
| sdo_oe | output | 1 | High while the responder drives `sdo` |

## Verification
Every output is a register. It changes one block clock after the block clock edge that first sees a new `sclk` or `sel` level. So the dummy zero, each data bit and the release are all due one cycle after the matching serial clock transition. The bench changes `sclk` and `sel` on falling block clock edges. It then waits two full block clocks before it samples, so every check lands at least a whole cycle after its result is due. The bench also reads each data bit once more after the following rising `sclk` edge, to confirm the bit held through the high phase. It probes `sdo_oe` after every address bit, so an early drive is caught at the exact bit where it happens.

// File: rtl/ee_resp_pkg.sv
// Shared definitions for the serial EEPROM responder.
// Assumes: a 3-bit command field and 16-bit storage words.
package ee_resp_pkg;

    localparam int          CMD_W    = 3;
    localparam logic [2:0]  CMD_READ = 3'b110;

    // Frame phases: command collection, address collection, word transmit,
    // and a quiet phase used after an unknown command or a finished word.
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_XMIT = 2'd2,
        PH_QUIET = 2'd3
    } phase_t;

endpackage

// File: rtl/ee_sclk_edge.sv
// Finds rising and falling serial clock edges by oversampling.
// Assumes: sclk is synchronous to clk and holds each level for at least one
// clk cycle. Both pulses last one clk cycle, in the cycle the new level is seen.
module ee_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    // Remember the serial clock level from the previous block clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/ee_word_store.sv
// Word storage with a parallel write port and an asynchronous read port.
// Assumes: contents are loaded before serial reads; no reset of the array.
module ee_word_store #(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [WORDS];

    // Store a preload word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee_frame_ctrl.sv
// Serial frame decoder and transmitter.
// Collects the command and address on rising sclk edges. After a read
// address it drives a dummy zero, then shifts the word out MSB first on
// falling edges. Assumes: rise and fall come from an oversampling detector,
// and deasserted sel acts as a frame reset.
module ee_frame_ctrl
    import ee_resp_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          sdi,
    input  logic          rise,
    input  logic          fall,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          sdo,
    output logic          sdo_oe
);

    localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_W - 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] DATA_END  = CW'(DW);

    phase_t          phase;
    logic [CW-1:0]   cnt;
    logic [CMD_W-1:0] cmd_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   shift_q;
    logic [CMD_W-1:0] cmd_next;

    // Next command and address values, including the bit on sdi.
    always_comb begin
        cmd_next = {cmd_q[CMD_W-2:0], sdi};
        rd_addr  = {addr_q[AW-2:0], sdi};
    end

    // Frame sequencing, bit counting and output drive.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase   <= PH_CMD;
            cnt     <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            shift_q <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            unique case (phase)
                PH_CMD: begin
                    if (rise) begin
                        cmd_q <= cmd_next;
                        if (cnt == CMD_LAST) begin
                            cnt   <= '0;
                            phase <= (cmd_next == CMD_READ) ? PH_ADDR : PH_QUIET;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (rise) begin
                        addr_q <= rd_addr;
                        if (cnt == ADDR_LAST) begin
                            cnt     <= '0;
                            shift_q <= rd_data;
                            sdo     <= 1'b0;
                            sdo_oe  <= 1'b1;
                            phase   <= PH_XMIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_XMIT: begin
                    if (fall) begin
                        if (cnt == DATA_END) begin
                            sdo    <= 1'b0;
                            sdo_oe <= 1'b0;
                            phase  <= PH_QUIET;
                        end else begin
                            sdo     <= shift_q[DW-1];
                            shift_q <= {shift_q[DW-2:0], 1'b0};
                            cnt     <= cnt + 1'b1;
                        end
                    end
                end
                PH_QUIET: begin
                    sdo    <= 1'b0;
                    sdo_oe <= 1'b0;
                end
                default: phase <= PH_CMD;
            endcase
        end
    end

    // R4: the drive starts only on a rising serial clock edge
    p_drive_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(rise));

    // R5: the first driven bit is the dummy zero
    p_dummy_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R6: a driven bit changes only after a falling serial clock edge
    p_bit_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && (sdo != $past(sdo))) |-> $past(fall));

    // R7: the drive ends on a falling edge or on chip select removal
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> ($past(fall) || !$past(sel)));

endmodule

// File: rtl/ee_responder.sv
// Top of the three-wire serial EEPROM responder.
// Joins the edge detector, the word store and the frame controller.
// Assumes: WORDS is 64 or 256, and every input is synchronous to clk.
module ee_responder #(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          sel,
    input  logic          sclk,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe
);

    if (WORDS != 64 && WORDS != 256) begin : g_bad_size
        $error("ee_responder: WORDS must be 64 or 256");
    end

    logic          sclk_rise;
    logic          sclk_fall;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    ee_sclk_edge i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    ee_word_store #(.WORDS(WORDS), .DW(DW)) i_store (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ee_frame_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .sdi     (sdi),
        .rise    (sclk_rise),
        .fall    (sclk_fall),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    // R8: removing chip select stops the drive by the next clock
    p_sel_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdo_oe);

endmodule

// File: tb/test_ee_responder.sv
`timescale 1ns/1ps
module test_ee_responder;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, sel, sclk, sdi;
    logic        ld_a, ld_b;
    logic [7:0]  ld_addr;
    logic [15:0] ld_data;
    logic        sdo_a, oe_a, sdo_b, oe_b;
    int          dev;
    logic        cur_sdo, cur_oe;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    ee_responder #(.WORDS(64)) i_ee_responder (
        .clk(clk), .rst_n(rst_n), .load_en(ld_a), .load_addr(ld_addr[5:0]),
        .load_data(ld_data), .sel(sel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo_a), .sdo_oe(oe_a));

    ee_responder #(.WORDS(256)) i_ee_responder_w256 (
        .clk(clk), .rst_n(rst_n), .load_en(ld_b), .load_addr(ld_addr),
        .load_data(ld_data), .sel(sel), .sclk(sclk), .sdi(sdi),
        .sdo(sdo_b), .sdo_oe(oe_b));

    always_comb begin
        cur_sdo = (dev != 0) ? sdo_b : sdo_a;
        cur_oe  = (dev != 0) ? oe_b  : oe_a;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int d, input int a);
        if (d == 0) return 16'(a * 733 + 16'h04C1) ^ 16'(a << 10);
        return 16'(a * 40503) ^ 16'hA5C3 ^ 16'(a << 7);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_hi();
        sclk = 1'b1; tick(2);
    endtask

    task automatic sck_lo();
        sclk = 1'b0; tick(2);
    endtask

    task automatic send_bit(input logic b);
        sdi = b; sck_hi(); sck_lo();
    endtask

    task automatic send_read_hdr(input int aw, input int a, output bit early);
        early = 0;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        for (int i = aw - 1; i >= 0; i--) begin
            sdi = a[i];
            sck_hi();
            if (i > 0) begin
                if (cur_oe !== 1'b0) early = 1;
            end else begin
                check(cur_oe === 1'b1 && cur_sdo === 1'b0, "R5 dummy zero",
                      {cur_oe, cur_sdo}, 2'b10);
            end
            sck_lo();
        end
    endtask

    // Full read frame: R3 R4 R5 R6 R7
    task automatic read_word(input int d, input int a);
        bit          early, stable;
        logic [15:0] got;
        int          aw;
        dev = d;
        aw = (d != 0) ? 8 : 6;
        sel = 1'b1; tick(2);
        send_read_hdr(aw, a, early);
        check(!early, "R4 no drive before last address bit", early, 0);
        stable = 1;
        for (int k = 0; k < 16; k++) begin
            got[15 - k] = cur_sdo;
            sck_hi();
            if (cur_sdo !== got[15 - k] || cur_oe !== 1'b1) stable = 0;
            sck_lo();
        end
        check(got === pat(d, a), "R2 R3 R6 read word", got, pat(d, a));
        check(stable, "R6 bit steady while sclk high", stable, 1);
        check(cur_oe === 1'b0 && cur_sdo === 1'b0, "R7 released after bit 0",
              {cur_oe, cur_sdo}, 0);
        sel = 1'b0; sdi = 1'b0; tick(2);
    endtask

    initial begin
        #(20ns * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit early, bad;
        rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0;
        ld_a = 1'b0; ld_b = 1'b0; ld_addr = '0; ld_data = '0; dev = 0;
        tick(4);
        // R1: outputs quiet in reset and just after
        check(oe_a === 1'b0 && sdo_a === 1'b0 && oe_b === 1'b0 && sdo_b === 1'b0,
              "R1 reset state", {oe_a, sdo_a, oe_b, sdo_b}, 0);
        rst_n = 1'b1; tick(1);
        check(oe_a === 1'b0 && sdo_a === 1'b0 && oe_b === 1'b0 && sdo_b === 1'b0,
              "R1 after reset", {oe_a, sdo_a, oe_b, sdo_b}, 0);

        // R2: preload both stores
        for (int a = 0; a < 64; a++) begin
            ld_a = 1'b1; ld_addr = 8'(a); ld_data = pat(0, a); tick(1);
        end
        ld_a = 1'b0;
        for (int a = 0; a < 256; a++) begin
            ld_b = 1'b1; ld_addr = 8'(a); ld_data = pat(1, a); tick(1);
        end
        ld_b = 1'b0; tick(2);

        // R3: every address of both sizes
        for (int a = 0; a < 64; a++) read_word(0, a);
        for (int a = 0; a < 256; a++) read_word(1, a);

        // R8: drop chip select mid-command, mid-address and mid-word
        for (int d = 0; d < 2; d++) begin
            dev = d;
            sel = 1'b1; tick(2);
            send_bit(1'b1); send_bit(1'b1);
            sel = 1'b0; tick(2);
            read_word(d, 5);
            sel = 1'b1; tick(2);
            send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
            sel = 1'b0; tick(2);
            check(cur_oe === 1'b0, "R8 quiet after address abort", cur_oe, 0);
            read_word(d, 33);
            sel = 1'b1; tick(2);
            send_read_hdr((d != 0) ? 8 : 6, 17, early);
            for (int k = 0; k < 5; k++) begin sck_hi(); sck_lo(); end
            check(cur_oe === 1'b1, "R8 driving before abort", cur_oe, 1);
            sel = 1'b0; tick(2);
            check(cur_oe === 1'b0 && cur_sdo === 1'b0, "R8 quiet after word abort",
                  {cur_oe, cur_sdo}, 0);
            read_word(d, 17);
        end

        // R9: every non-read command is ignored for the whole frame
        for (int d = 0; d < 2; d++) begin
            for (int op = 0; op < 8; op++) begin
                if (op == 6) continue;
                dev = d;
                bad = 0;
                sel = 1'b1; tick(2);
                send_bit(op[2]); send_bit(op[1]); send_bit(op[0]);
                for (int j = 0; j < 28; j++) begin
                    sdi = j[0] ^ j[2];
                    sck_hi();
                    if (cur_oe !== 1'b0) bad = 1;
                    sck_lo();
                    if (cur_oe !== 1'b0) bad = 1;
                end
                check(!bad, $sformatf("R9 command %0d ignored", op), bad, 0);
                sel = 1'b0; tick(2);
                read_word(d, op + 40);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule